// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator with Full-Duty Override

This block produces one pulse-width-modulated output from a single 32-bit control word. A programmable prescaler divides the source clock by (divisor field + 1). Each prescaler tick advances an 8-bit phase counter, so one output period always spans 256 prescaled ticks. The output is high while the phase is below the programmed duty value. A dedicated override bit holds the output high for the whole period, which no 8-bit duty value can do. An enable bit gates everything, and while it is clear the output is low.

The control word is loaded by a one-cycle write strobe and can be read back at any time. A write takes effect on the clock edge that accepts it. That edge also zeroes both the prescaler and the phase counter, so any running period is cut short and the new setting starts from phase 0. Clearing the enable stops the output at once, without finishing the current period. The write port is a plain control input with no back-pressure: every strobed cycle is accepted.

Control word layout: divisor in bits [12:0], duty in bits [23:16], full-duty override in bit 24, enable in bit 31. All other bits are reserved.

Top module: `duty_pwm`

## Requirements
- R1: After synchronous reset the control word reads 0 and `pwm_out` is 0.
- R2: `rd_data` returns the last written word with every bit outside [12:0], [23:16], 24 and 31 forced to 0.
- R3: With enable set, override clear and duty nonzero, `pwm_out` rises again exactly 256*(S+1) clock cycles after the write edge, where S is the value in bits [12:0].
- R4: Counting the cycle after the write edge as cycle 0, `pwm_out` is high in cycles 0 to D*(S+1)-1 of each period and low for the rest, where D is the value in bits [23:16].
- R5: With bits 31 and 24 both set, `pwm_out` stays high on every cycle, whatever bits [23:16] hold.
- R6: With bit 31 set, bit 24 clear and bits [23:16] equal to 0, `pwm_out` stays low.
- R7: With bit 31 clear, `pwm_out` is 0 regardless of duty and override.
- R8: A write that clears bit 31 drives `pwm_out` low in the cycle right after the write edge, even in mid-period.
- R9: A write while running restarts the prescaler and phase counter from 0 on the write edge. The new duty and divisor govern the output from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word, one cycle per write |
| wr_data | input | 32 | Control word to be written |
| rd_data | output | 32 | Current control word, reserved bits zero |
| pwm_out | output | 1 | Modulated output |

## Verification
The assertions assume that `wr_en` and `wr_data` are known (not X) on every clock edge after reset. They also assume that a write changes all fields together in the cycle of its strobe. The bench meets this by driving both inputs on the falling edge from one task, and it holds `wr_en` low except for single-cycle writes. The checks on counting and phase stepping rely on the divisor changing only through a write, which also zeroes the counters. The stimulus therefore uses no other path to change settings in mid-period. Divisor values are kept small so that full periods fit in the run, and one write exercises the widest divisor across a few prescaled ticks.

// File: rtl/duty_pwm_pkg.sv
package duty_pwm_pkg;
  localparam int CTRL_W   = 32;
  localparam int DIV_W    = 13;
  localparam int DUTY_W   = 8;
  localparam int DIV_LSB  = 0;
  localparam int DUTY_LSB = 16;
  localparam int FULL_BIT = 24;
  localparam int EN_BIT   = 31;

  typedef struct packed {
    logic              en;
    logic              full;
    logic [DUTY_W-1:0] duty;
    logic [DIV_W-1:0]  divisor;
  } pwm_cfg_t;

  localparam logic [CTRL_W-1:0] LIVE_MASK =
    (CTRL_W'(1) << EN_BIT) | (CTRL_W'(1) << FULL_BIT) |
    (CTRL_W'((1 << DUTY_W) - 1) << DUTY_LSB) |
    (CTRL_W'((1 << DIV_W) - 1) << DIV_LSB);

  function automatic pwm_cfg_t cfg_from_word(input logic [CTRL_W-1:0] w);
    pwm_cfg_t c;
    c.en      = w[EN_BIT];
    c.full    = w[FULL_BIT];
    c.duty    = w[DUTY_LSB +: DUTY_W];
    c.divisor = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] word_from_cfg(input pwm_cfg_t c);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[EN_BIT]                = c.en;
    w[FULL_BIT]              = c.full;
    w[DUTY_LSB +: DUTY_W]    = c.duty;
    w[DIV_LSB +: DIV_W]      = c.divisor;
    return w;
  endfunction
endpackage

// File: rtl/duty_pwm_regs.sv
module duty_pwm_regs
  import duty_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output pwm_cfg_t          cfg,
  output logic [CTRL_W-1:0] rd_data
);
  pwm_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_from_word(wr_data);
  end

  assign cfg     = cfg_q;
  assign rd_data = word_from_cfg(cfg_q);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE_MASK) == '0);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0));
endmodule

// File: rtl/duty_pwm_presc.sv
module duty_pwm_presc #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == divisor);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (tick)              cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= divisor);

  // R9
  presc_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
endmodule

// File: rtl/duty_pwm_phase.sv
module duty_pwm_phase #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic              tick,
  output logic [DUTY_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst || restart || !run) phase <= '0;
    else if (tick)              phase <= phase + 1'b1;
  end

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !restart) |=> (phase == DUTY_W'($past(phase) + 1'b1)));

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && run && !restart) |=> $stable(phase));
endmodule

// File: rtl/duty_pwm_cmp.sv
module duty_pwm_cmp #(
  parameter int DUTY_W = 8
) (
  input  logic              run,
  input  logic              full,
  input  logic [DUTY_W-1:0] duty,
  input  logic [DUTY_W-1:0] phase,
  output logic              level
);
  logic below;

  always_comb begin
    below = (phase < duty);
    level = run && (full || below);
  end
endmodule

// File: rtl/duty_pwm.sv
module duty_pwm
  import duty_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  pwm_cfg_t          cfg;
  logic              tick;
  logic [DUTY_W-1:0] phase;

  duty_pwm_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .rd_data(rd_data)
  );

  duty_pwm_presc #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .run(cfg.en), .restart(wr_en),
    .divisor(cfg.divisor), .tick(tick)
  );

  duty_pwm_phase #(.DUTY_W(DUTY_W)) u_phase (
    .clk(clk), .rst(rst), .run(cfg.en), .restart(wr_en),
    .tick(tick), .phase(phase)
  );

  duty_pwm_cmp #(.DUTY_W(DUTY_W)) u_cmp (
    .run(cfg.en), .full(cfg.full), .duty(cfg.duty),
    .phase(phase), .level(pwm_out)
  );

  // R5
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[EN_BIT] && rd_data[FULL_BIT]) |-> pwm_out);

  // R6
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[EN_BIT] && !rd_data[FULL_BIT] &&
     rd_data[DUTY_LSB +: DUTY_W] == '0) |-> !pwm_out);

  // R8
  stop_now_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[EN_BIT]) |=> !pwm_out);

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (phase == '0));
endmodule

// File: tb/duty_pwm_bench.sv
module duty_pwm_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  // reference state: control word and cycles since last write
  logic [31:0] m_word = '0;
  int          m_t    = 0;

  localparam logic [31:0] MASK = 32'h81FF_1FFF;

  always #4 clk = ~clk;

  duty_pwm u_duty_pwm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  function automatic logic ref_out();
    int s, d, ph;
    s  = int'(m_word[12:0]) + 1;
    d  = int'(m_word[23:16]);
    ph = (m_t / s) % 256;
    return m_word[31] && (m_word[24] || (ph < d));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_word = '0; m_t = 0;
    end else if (wr_en) begin
      m_word = wr_data & MASK; m_t = 0;
    end else if (m_word[31]) begin
      m_t = m_t + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison with the reference model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(pwm_out == ref_out(), cur_req, "pwm_out vs model", pwm_out, ref_out());
      check(rd_data == m_word, cur_req, "rd_data vs model", rd_data, m_word);
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] cw(input bit en, input bit full,
                                     input int duty, input int div);
    return {en, 6'b0, full, 8'(duty), 3'b0, 13'(div)};
  endfunction

  task automatic high_time(input int duty, input int div);
    int hi = 0;
    int rise = -1;
    logic prev = 1'b1;
    wr(cw(1, 0, duty, div));
    for (int i = 0; i < 256 * (div + 1) + 4; i++) begin
      if (i < 256 * (div + 1) && pwm_out) hi++;
      if (pwm_out && !prev && rise < 0) rise = i;
      prev = pwm_out;
      @(negedge clk);
    end
    check(hi == duty * (div + 1), "R4", "high cycles", hi, duty * (div + 1));
    check(rise == 256 * (div + 1), "R3", "cycles to next rise", rise, 256 * (div + 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data == 32'h0, "R1", "rd_data after reset", rd_data, 0);
    check(pwm_out == 1'b0, "R1", "pwm_out after reset", pwm_out, 0);
    rst = 1'b0;
    @(negedge clk);

    cur_req = "R2";
    wr(32'hFFFF_FFFF);
    check(rd_data == MASK, "R2", "reserved bits masked", rd_data, MASK);
    wr(32'h7E00_E000);
    check(rd_data == 32'h0, "R2", "only reserved bits written", rd_data, 0);

    cur_req = "R4";
    high_time(64, 0);
    high_time(1, 1);
    high_time(255, 0);
    high_time(100, 3);

    cur_req = "R5";
    wr(cw(1, 1, 0, 0));
    for (int i = 0; i < 300; i++) begin
      if (!pwm_out) check(1'b0, "R5", "override high", pwm_out, 1);
      @(negedge clk);
    end
    check(pwm_out == 1'b1, "R5", "override with duty 0", pwm_out, 1);

    cur_req = "R6";
    wr(cw(1, 0, 0, 0));
    repeat (300) @(negedge clk);
    check(pwm_out == 1'b0, "R6", "zero duty low", pwm_out, 0);

    cur_req = "R7";
    wr(cw(0, 1, 255, 0));
    repeat (20) @(negedge clk);
    check(pwm_out == 1'b0, "R7", "disabled with override", pwm_out, 0);

    cur_req = "R8";
    wr(cw(1, 0, 200, 0));
    repeat (10) @(negedge clk);
    check(pwm_out == 1'b1, "R8", "running high before stop", pwm_out, 1);
    wr(cw(0, 0, 200, 0));
    check(pwm_out == 1'b0, "R8", "low right after disable", pwm_out, 0);

    cur_req = "R9";
    wr(cw(1, 0, 50, 0));
    repeat (100) @(negedge clk);
    check(pwm_out == 1'b0, "R9", "past duty before rewrite", pwm_out, 0);
    wr(cw(1, 0, 10, 0));
    check(pwm_out == 1'b1, "R9", "restart from phase 0", pwm_out, 1);
    repeat (9) @(negedge clk);
    check(pwm_out == 1'b1, "R9", "last high cycle", pwm_out, 1);
    @(negedge clk);
    check(pwm_out == 1'b0, "R9", "first low cycle", pwm_out, 0);

    cur_req = "R3";
    wr(cw(1, 0, 2, 8191));
    repeat (8192) @(negedge clk);
    check(pwm_out == 1'b1, "R3", "widest divisor still phase 1", pwm_out, 1);
    repeat (8192) @(negedge clk);
    check(pwm_out == 1'b0, "R3", "widest divisor phase 2", pwm_out, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL %s watchdog: actual=%0d expected=%0d", cur_req, 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule